// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Modulator

This block decides how many input clocks each output cycle of a synthesizer loop divider lasts. It takes an integer divide value N and a fractional word. In every divider cycle it adds the fractional word to a phase accumulator that wraps at 2^W. When the addition overflows, that cycle divides by N+1. Otherwise it divides by N. Over a long run the mean ratio is N + K/2^W. A built-in down-counter divides the input clock by the chosen ratio. It raises a one-clock boundary pulse at the end of every divider cycle.

The lowest bit of the effective fractional word is always 1. Software supplies only the upper W-1 bits. Because K is therefore odd, the accumulator runs through all 2^W states before it repeats, so no short limit cycle can form. N and the fractional bits are sampled only on the clock that ends a divider cycle. A register write in the middle of a cycle cannot shorten or stretch it.

Top module: `fracn_mod`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first clock after it, the outputs are: `tick_o`=1, `phase_o`=0, `ratio_o`=0 and `carry_o`=0. The clock edge after reset is released is a cycle boundary.
- R2: The effective fractional word is K = {k_frac_i, 1'b1}, with k_frac_i in bits W-1..1 and bit 0 fixed at 1. On every boundary, `phase_o` becomes (phase_o + K) mod 2^W.
- R3: On a boundary, `carry_o` becomes the overflow of that addition. `ratio_o` becomes N_eff + carry_o, where N_eff is the clamped N of R6.
- R4: `tick_o` is high for exactly one clock in every `ratio_o` clocks. The cycle begun at a boundary lasts `ratio_o` input clocks, and its last clock has `tick_o`=1.
- R5: `n_int_i` and `k_frac_i` are sampled only on a clock edge where `tick_o` is 1. A change at any other time has no effect on the length or ratio of the running cycle.
- R6: An N value below 2 is treated as 2.
- R7: Start from phase 0 and hold K constant. After exactly 2^W boundaries, the number of boundaries with `carry_o`=1 equals K and `phase_o` is 0 again. `phase_o` is never 0 after an earlier boundary of that run.
- R8: Between boundaries, `ratio_o`, `carry_o` and `phase_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| n_int_i | input | N_W | Integer divide value N |
| k_frac_i | input | K_W-1 | Programmable fractional bits K[W-1:1] |
| tick_o | output | 1 | Last clock of the current divider cycle |
| ratio_o | output | N_W+1 | Ratio of the running divider cycle |
| carry_o | output | 1 | Accumulator overflow of the last boundary |
| phase_o | output | K_W | Fractional accumulator phase |

## Verification
The bench builds the block with a 10-bit accumulator and a 6-bit N instead of the 22-bit default. A full accumulator period is then 1024 boundaries. At ratios of 2 or 3 clocks, several full periods fit in the run, so R7 is checked exactly for K=1, K=1023 and one K in between. The 6-bit N still lets random stimulus reach both the clamp at N below 2 and ratios up to 64. Mid-cycle register writes show that the inputs are sampled only at boundaries.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    // smallest divide value the counter can honour (reload of ratio-1 must be >= 1)
    localparam int FRACN_N_MIN   = 2;
    localparam int FRACN_N_W_DEF = 8;
    localparam int FRACN_K_W_DEF = 22;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
    parameter int K_W = fracn_pkg::FRACN_K_W_DEF
) (
    input  logic [K_W-1:0] phase_i,
    input  logic [K_W-2:0] k_prog_i,
    output logic [K_W-1:0] phase_o,
    output logic           carry_o
);
    logic [K_W:0]   sum;
    logic [K_W-1:0] k_eff;

    // bit 0 forced high: odd step gives a full-length accumulator sequence
    assign k_eff   = {k_prog_i, 1'b1};
    assign sum     = {1'b0, phase_i} + {1'b0, k_eff};
    assign phase_o = sum[K_W-1:0];
    assign carry_o = sum[K_W];
endmodule

// File: rtl/fracn_ratio.sv
module fracn_ratio #(
    parameter int N_W = fracn_pkg::FRACN_N_W_DEF
) (
    input  logic [N_W-1:0] n_i,
    input  logic           carry_i,
    output logic [N_W:0]   ratio_o,
    output logic [N_W:0]   load_o
);
    import fracn_pkg::*;

    localparam logic [N_W-1:0] NMIN = N_W'(FRACN_N_MIN);

    logic [N_W-1:0] n_eff;

    always_comb begin
        n_eff   = (n_i < NMIN) ? NMIN : n_i;
        ratio_o = {1'b0, n_eff} + {{N_W{1'b0}}, carry_i};
        load_o  = ratio_o - {{N_W{1'b0}}, 1'b1};
    end
endmodule

// File: rtl/fracn_mod.sv
module fracn_mod #(
    parameter int N_W = fracn_pkg::FRACN_N_W_DEF,
    parameter int K_W = fracn_pkg::FRACN_K_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_int_i,
    input  logic [K_W-2:0] k_frac_i,
    output logic           tick_o,
    output logic [N_W:0]   ratio_o,
    output logic           carry_o,
    output logic [K_W-1:0] phase_o
);
    typedef struct packed {
        logic [N_W:0]   cnt;
        logic [N_W:0]   ratio;
        logic           carry;
        logic [K_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    logic [K_W-1:0] acc_next;
    logic           acc_carry;
    logic [N_W:0]   ratio_new;
    logic [N_W:0]   load_new;
    logic           boundary;

    fracn_acc #(.K_W(K_W)) u_acc (
        .phase_i  (st_q.phase),
        .k_prog_i (k_frac_i),
        .phase_o  (acc_next),
        .carry_o  (acc_carry)
    );

    fracn_ratio #(.N_W(N_W)) u_ratio (
        .n_i     (n_int_i),
        .carry_i (acc_carry),
        .ratio_o (ratio_new),
        .load_o  (load_new)
    );

    assign boundary = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            // inputs only matter here, so a cycle is never cut short
            st_d.phase = acc_next;
            st_d.carry = acc_carry;
            st_d.ratio = ratio_new;
            st_d.cnt   = load_new;
        end else begin
            st_d.cnt = st_q.cnt - {{N_W{1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o  = boundary;
    assign ratio_o = st_q.ratio;
    assign carry_o = st_q.carry;
    assign phase_o = st_q.phase;
endmodule

// File: rtl/fracn_mod_chk.sv
module fracn_mod_chk #(
    parameter int N_W = 8,
    parameter int K_W = 22
) (
    input logic           clk,
    input logic           rst,
    input logic [N_W-1:0] n_int_i,
    input logic           tick_o,
    input logic [N_W:0]   ratio_o,
    input logic           carry_o,
    input logic [K_W-1:0] phase_o
);
    logic [N_W:0] n_exp;
    logic [N_W:0] run_q;
    logic         seen_q;

    assign n_exp = (n_int_i < N_W'(2)) ? (N_W+1)'(2) : {1'b0, n_int_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_o) begin
            run_q  <= (N_W+1)'(1);
            seen_q <= 1'b1;
        end else begin
            run_q  <= run_q + (N_W+1)'(1);
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tick_o && phase_o == '0 && ratio_o == '0 && !carry_o));

    a_r2_odd_step: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (phase_o[0] != $past(phase_o[0])));

    a_r3_carry_wrap: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (carry_o == (phase_o < $past(phase_o))));

    a_r6_ratio_from_n: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (ratio_o == $past(n_exp) + {{N_W{1'b0}}, carry_o}));

    a_r4_cycle_len: assert property (@(posedge clk) disable iff (rst)
        (tick_o && seen_q) |-> (run_q == ratio_o));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> ($stable(ratio_o) && $stable(phase_o) && $stable(carry_o)));
endmodule

bind fracn_mod fracn_mod_chk #(.N_W(N_W), .K_W(K_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .n_int_i (n_int_i),
    .tick_o  (tick_o),
    .ratio_o (ratio_o),
    .carry_o (carry_o),
    .phase_o (phase_o)
);

// File: tb/fracn_mod_test.sv
module fracn_mod_test;
    localparam int N_W = 6;
    localparam int K_W = 10;
    localparam int MOD = 1 << K_W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N_W-1:0] n_drv = '0;
    logic [K_W-2:0] k_drv = '0;
    logic           tick_o;
    logic [N_W:0]   ratio_o;
    logic           carry_o;
    logic [K_W-1:0] phase_o;

    int errors = 0;
    int checks = 0;
    int m_cnt = 0, m_ratio = 0, m_carry = 0, m_acc = 0;

    always #10 clk = ~clk;

    fracn_mod #(.N_W(N_W), .K_W(K_W)) uut (
        .clk(clk), .rst(rst), .n_int_i(n_drv), .k_frac_i(k_drv),
        .tick_o(tick_o), .ratio_o(ratio_o), .carry_o(carry_o), .phase_o(phase_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_eff(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // one clock: model the edge from the requirements, then compare at negedge
    task automatic step();
        int s;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_ratio = 0; m_carry = 0;
        end else if (m_cnt == 0) begin
            s       = m_acc + int'(k_drv) * 2 + 1;
            m_carry = (s >= MOD) ? 1 : 0;
            m_acc   = s % MOD;
            m_ratio = n_eff(int'(n_drv)) + m_carry;
            m_cnt   = m_ratio - 1;
        end else begin
            m_cnt--;
        end
        @(negedge clk);
        chk(int'(tick_o) == ((m_cnt == 0) ? 1 : 0), "R4 tick", int'(tick_o), (m_cnt == 0) ? 1 : 0);
        chk(int'(ratio_o) == m_ratio, "R3 ratio", int'(ratio_o), m_ratio);
        chk(int'(carry_o) == m_carry, "R3 carry", int'(carry_o), m_carry);
        chk(int'(phase_o) == m_acc, "R2 phase", int'(phase_o), m_acc);
    endtask

    task automatic wait_boundary();
        while (tick_o !== 1'b1) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        // R1: reset state
        chk(tick_o === 1'b1 && phase_o == '0 && ratio_o == '0 && carry_o === 1'b0,
            "R1 reset", int'(ratio_o), 0);
        rst = 1'b0;
    endtask

    task automatic full_run(input int n, input int kp);
        int hits = 0;
        int early = 0;
        do_reset();
        n_drv = N_W'(n);
        k_drv = (K_W-1)'(kp);
        for (int i = 0; i < MOD; i++) begin
            wait_boundary();
            step();
            if (carry_o) hits++;
            if (i < MOD - 1 && phase_o == '0) early++;
        end
        chk(hits == kp * 2 + 1, "R7 carry count", hits, kp * 2 + 1);
        chk(phase_o == '0, "R7 phase return", int'(phase_o), 0);
        chk(early == 0, "R7 full length", early, 0);
    endtask

    initial begin
        int r, len;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R7 corner and mid-range K
        full_run(2, 0);
        full_run(2, (1 << (K_W - 1)) - 1);
        full_run(3, 300);

        // R5: mid-cycle writes ignored
        n_drv = 6'd5;
        k_drv = 9'd77;
        wait_boundary();
        step();
        r = int'(ratio_o);
        chk(r - int'(carry_o) == 5, "R5 sampled N", r - int'(carry_o), 5);
        n_drv = 6'd9;
        k_drv = 9'd400;
        len = 1;
        while (tick_o !== 1'b1) begin
            step();
            len++;
        end
        chk(len == r, "R5 cycle length", len, r);
        chk(int'(ratio_o) == r, "R5 ratio held", int'(ratio_o), r);
        // R8: ratio held through the cycle (also compared every clock)
        chk(int'(ratio_o) == r, "R8 hold", int'(ratio_o), r);

        // R6: clamp of N below 2
        for (int v = 0; v < 2; v++) begin
            n_drv = N_W'(v);
            wait_boundary();
            step();
            chk(int'(ratio_o) - int'(carry_o) == 2, "R6 clamp", int'(ratio_o) - int'(carry_o), 2);
        end

        // R4: large N
        n_drv = '1;
        wait_boundary();
        step();
        chk(int'(ratio_o) >= 63, "R4 large ratio", int'(ratio_o), 63);

        // random register writes at random times
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 8) == 0) n_drv = N_W'($urandom);
            if (($urandom % 8) == 0) k_drv = (K_W-1)'($urandom);
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule